// File: doc/BRIEF.md
# Bus Buffer Connection Supervisor

This block is the digital supervisor of a two-wire bus buffer that joins an input-side bus segment to an output-side segment. It watches the data and clock lines of both segments and an enable input. It drives a `connect` output that closes the path between the two segments. It also drives two status flags: `bus_ready`, which is low while the path is not in service, and `fault_n`, which is low after a line has been held low for too long.

After enable rises, the block waits until traffic on both segments has finished, and only then joins them. A segment counts as finished when a STOP condition has been seen on it, or when its two lines have both stayed high for `IDLE_CYC` clock cycles. While the segments are joined, a line held low for `STUCK_CYC` cycles opens the path and raises the fault. A new rising edge on enable while the fault is present joins the segments again by force, even if the line is still low. The stuck-low timers then restart from zero and stay armed. The fault also clears when all four lines return high. After that, the block waits for idle in the normal way before it reconnects.

All five inputs pass through two-flop synchronizers. The analog buffering and the pad drive are out of scope.

Top module: `bus_buffer_supervisor`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `connect`=0, `bus_ready`=0 and `fault_n`=1.
- R2: Suppose `en_in` falls while the segments are joined, and the change is applied after clock edge h. Then `connect` and `bus_ready` are both 0 from edge h+3 on. Up to and including edge h+2 they are unchanged.
- R3: Suppose `en_in` rises after edge c, and all four lines stay high. Then `connect` is still 0 after edge c+3+IDLE_CYC and becomes 1 after edge c+4+IDLE_CYC.
- R4: A STOP condition on a segment marks that segment as idle. A STOP is `sda` going from 0 to 1 while `scl` is 1. If the other segment is already idle and the rise is applied after edge d, then `connect` is 0 after edge d+3 and 1 after edge d+4. A segment whose `sda` stays low never counts as idle, so `connect` stays 0.
- R5: `bus_ready` is 1 exactly when `connect` is 1. It is 0 in the idle-wait state, in the disabled state and in the fault state.
- R6: While joined, suppose a wired-AND line goes low after edge s and stays low. The wired-AND lines are in_sda&out_sda and in_scl&out_scl. Then `connect`=1 and `fault_n`=1 after edge s+2+STUCK_CYC, and `connect`=0, `bus_ready`=0 and `fault_n`=0 after edge s+3+STUCK_CYC. A low run shorter than STUCK_CYC cycles raises no fault.
- R7: In the fault state, `en_in` may fall and then rise, with the rise applied after edge f. The block then stays in fault through edge f+2. After edge f+3 it has `connect`=1, `bus_ready`=1 and `fault_n`=1, even if the line is still low.
- R8: After a forced reconnection at edge r, a line that is still low faults again after edge r+1+STUCK_CYC. This holds because the timer restarted from zero.
- R9: In the fault state with `en_in` high, suppose the last low line returns high after edge g. Then `fault_n` is 0 after edge g+2 and 1 after edge g+3, with `connect`=0. The segments join after edge g+4+IDLE_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en_in | input | 1 | Enable request, asynchronous |
| in_sda | input | 1 | Input-segment data line level |
| in_scl | input | 1 | Input-segment clock line level |
| out_sda | input | 1 | Output-segment data line level |
| out_scl | input | 1 | Output-segment clock line level |
| connect | output | 1 | 1 closes the path between the segments |
| bus_ready | output | 1 | 0 while the path is not in service |
| fault_n | output | 1 | 0 while a stuck-low fault is present |

## Verification
Every result is due a fixed number of edges after the input change that causes it. The synchronizers add two edges. Each registered stage adds one more edge: the idle flag, the timer and the state. This gives 3 edges for a disable or a fault release, 3 after the second enable edge for a forced reconnection, 4 after a STOP, 4+IDLE_CYC after enable on idle lines, and 3+STUCK_CYC for a stuck line. For each stimulus, the driver records the edge number at which it acts and queues the expected outputs for the last edge before the change and for the edge of the change. The monitor compares them on the falling clock edge that follows each numbered rising edge. An off-by-one in any stage therefore fails one of the two paired checks.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WAIT  = 2'd1,
        ST_ON    = 2'd2,
        ST_FAULT = 2'd3
    } bbs_state_e;

    typedef struct packed {
        logic sda;
        logic scl;
    } bus_pair_t;

    function automatic logic is_stop(input logic sda_prev, input bus_pair_t now);
        return now.scl && now.sda && !sda_prev;
    endfunction

    function automatic logic is_start(input logic sda_prev, input bus_pair_t now);
        return now.scl && !now.sda && sda_prev;
    endfunction

    function automatic logic pair_high(input bus_pair_t p);
        return p.sda && p.scl;
    endfunction

endpackage

// File: rtl/bbs_sync.sv
module bbs_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/bbs_idle_det.sv
module bbs_idle_det
    import bbs_pkg::*;
#(
    parameter int IDLE_CYC = 1000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      arm,
    input  bus_pair_t line,
    output logic      idle
);
    localparam int CW = $clog2(IDLE_CYC + 1);
    localparam logic [CW-1:0] CMAX = CW'(IDLE_CYC);

    logic          sda_prev_q;
    logic          stop_q;
    logic [CW-1:0] quiet_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sda_prev_q <= 1'b1;
            stop_q     <= 1'b0;
            quiet_q    <= '0;
        end else begin
            sda_prev_q <= line.sda;
            if (!arm) begin
                stop_q  <= 1'b0;
                quiet_q <= '0;
            end else begin
                if (is_stop(sda_prev_q, line))
                    stop_q <= 1'b1;
                else if (is_start(sda_prev_q, line))
                    stop_q <= 1'b0;
                if (!pair_high(line))
                    quiet_q <= '0;
                else if (quiet_q != CMAX)
                    quiet_q <= quiet_q + 1'b1;
            end
        end
    end

    assign idle = stop_q || (quiet_q == CMAX);
endmodule

// File: rtl/bbs_stuck_timer.sv
module bbs_stuck_timer
    import bbs_pkg::*;
#(
    parameter int STUCK_CYC = 3_000_000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  bus_pair_t wired,
    output logic      expired
);
    localparam int NLANE = 2;
    localparam int CW    = $clog2(STUCK_CYC + 1);
    localparam logic [CW-1:0] CMAX = CW'(STUCK_CYC);

    logic [NLANE-1:0] lane_lvl;
    logic [NLANE-1:0] lane_hit;

    assign lane_lvl = {wired.sda, wired.scl};

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic [CW-1:0] low_q;
        always_ff @(posedge clk) begin
            if (rst || !run || lane_lvl[g])
                low_q <= '0;
            else if (low_q != CMAX)
                low_q <= low_q + 1'b1;
        end
        assign lane_hit[g] = (low_q == CMAX);
    end

    assign expired = |lane_hit;
endmodule

// File: rtl/bus_buffer_supervisor.sv
module bus_buffer_supervisor
    import bbs_pkg::*;
#(
    parameter int IDLE_CYC  = 1000,
    parameter int STUCK_CYC = 3_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic en_in,
    input  logic in_sda,
    input  logic in_scl,
    input  logic out_sda,
    input  logic out_scl,
    output logic connect,
    output logic bus_ready,
    output logic fault_n
);
    localparam int NSYNC = 5;
    localparam logic [NSYNC-1:0] SYNC_RST = 5'b0_1111;

    logic [NSYNC-1:0] raw_v;
    logic [NSYNC-1:0] syn_v;
    logic             en_s;
    logic             en_prev_q;
    logic             en_rise;
    bus_pair_t        side_in;
    bus_pair_t        side_out;
    bus_pair_t        wired;
    logic             idle_in;
    logic             idle_out;
    logic             both_idle;
    logic             all_high;
    logic             timed_out;
    bbs_state_e       state_q;
    bbs_state_e       state_d;

    assign raw_v = {en_in, in_sda, in_scl, out_sda, out_scl};

    bbs_sync #(.W(NSYNC), .RST_VAL(SYNC_RST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_v),
        .q   (syn_v)
    );

    assign en_s         = syn_v[4];
    assign side_in.sda  = syn_v[3];
    assign side_in.scl  = syn_v[2];
    assign side_out.sda = syn_v[1];
    assign side_out.scl = syn_v[0];
    assign wired.sda    = side_in.sda & side_out.sda;
    assign wired.scl    = side_in.scl & side_out.scl;
    assign all_high     = pair_high(side_in) && pair_high(side_out);

    always_ff @(posedge clk) begin
        if (rst) en_prev_q <= 1'b0;
        else     en_prev_q <= en_s;
    end
    assign en_rise = en_s && !en_prev_q;

    bbs_idle_det #(.IDLE_CYC(IDLE_CYC)) u_idle_in (
        .clk  (clk),
        .rst  (rst),
        .arm  (state_q == ST_WAIT),
        .line (side_in),
        .idle (idle_in)
    );

    bbs_idle_det #(.IDLE_CYC(IDLE_CYC)) u_idle_out (
        .clk  (clk),
        .rst  (rst),
        .arm  (state_q == ST_WAIT),
        .line (side_out),
        .idle (idle_out)
    );

    assign both_idle = idle_in && idle_out;

    bbs_stuck_timer #(.STUCK_CYC(STUCK_CYC)) u_stuck (
        .clk     (clk),
        .rst     (rst),
        .run     (state_q == ST_ON),
        .wired   (wired),
        .expired (timed_out)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (en_s) state_d = ST_WAIT;
            ST_WAIT: begin
                if (!en_s)          state_d = ST_OFF;
                else if (both_idle) state_d = ST_ON;
            end
            ST_ON: begin
                if (!en_s)          state_d = ST_OFF;
                else if (timed_out) state_d = ST_FAULT;
            end
            ST_FAULT: begin
                if (en_rise)        state_d = ST_ON;
                else if (all_high)  state_d = en_s ? ST_WAIT : ST_OFF;
            end
            default:                state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_OFF;
        else     state_q <= state_d;
    end

    assign connect   = (state_q == ST_ON);
    assign bus_ready = (state_q == ST_ON);
    assign fault_n   = (state_q != ST_FAULT);
endmodule

// File: rtl/bbs_checker.sv
module bbs_checker
    import bbs_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       en_s,
    input logic       en_rise,
    input logic       both_idle,
    input logic       all_high,
    input bbs_state_e state_q,
    input logic       connect,
    input logic       bus_ready,
    input logic       fault_n
);
    a_r2_disabled_opens: assert property (@(posedge clk) disable iff (rst)
        !en_s |=> !connect);

    a_r3_join_needs_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(connect) |-> $past(both_idle || en_rise));

    a_r6_fault_keeps_open: assert property (@(posedge clk) disable iff (rst)
        !fault_n |-> (!connect && !bus_ready));

    a_r7_forced_join: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FAULT && en_rise) |=> (connect && fault_n));

    a_r9_fault_release: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_n) |-> $past(all_high || en_rise));
endmodule

bind bus_buffer_supervisor bbs_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .en_s      (en_s),
    .en_rise   (en_rise),
    .both_idle (both_idle),
    .all_high  (all_high),
    .state_q   (state_q),
    .connect   (connect),
    .bus_ready (bus_ready),
    .fault_n   (fault_n)
);

// File: tb/tb_bus_buffer_supervisor.sv
module tb_bus_buffer_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int N = 6;
    localparam int T = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_in = 1'b0;
    logic in_sda = 1'b1, in_scl = 1'b1, out_sda = 1'b1, out_scl = 1'b1;
    logic connect, bus_ready, fault_n;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        logic  c;
        logic  r;
        logic  f;
        string tag;
    } exp_t;
    exp_t sb[$];

    bus_buffer_supervisor #(.IDLE_CYC(N), .STUCK_CYC(T)) dut (
        .clk(clk), .rst(rst), .en_in(en_in),
        .in_sda(in_sda), .in_scl(in_scl), .out_sda(out_sda), .out_scl(out_scl),
        .connect(connect), .bus_ready(bus_ready), .fault_n(fault_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(input int at, input logic c, input logic r,
                             input logic f, input string tag);
        exp_t e;
        e.at = at; e.c = c; e.r = r; e.f = f; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                checks++;
                if ({connect, bus_ready, fault_n} !== {sb[i].c, sb[i].r, sb[i].f}) begin
                    fails++;
                    $display("FAIL %s at edge %0d: connect/ready/fault_n actual %b%b%b expected %b%b%b",
                             sb[i].tag, cyc, connect, bus_ready, fault_n,
                             sb[i].c, sb[i].r, sb[i].f);
                end
                sb.delete(i);
            end
        end
    end

    initial begin
        int c;
        step(3);
        expect_at(cyc + 1, 1'b0, 1'b0, 1'b1, "R1 reset state");
        rst = 1'b0;
        expect_at(cyc + 1, 1'b0, 1'b0, 1'b1, "R1 first cycle after reset");
        step(4);

        // R3: enable with all lines idle
        en_in = 1'b1; c = cyc;
        expect_at(c + 3 + N, 1'b0, 1'b0, 1'b1, "R3 still open before idle window");
        expect_at(c + 4 + N, 1'b1, 1'b1, 1'b1, "R3 R5 joined after idle window");
        step(N + 7);

        // R2: disable while joined
        en_in = 1'b0; c = cyc;
        expect_at(c + 2, 1'b1, 1'b1, 1'b1, "R2 still joined");
        expect_at(c + 3, 1'b0, 1'b0, 1'b1, "R2 R5 opened on disable");
        step(5);

        // R4: input segment busy (sda low, scl high), finishes with STOP
        in_sda = 1'b0;
        step(3);
        en_in = 1'b1; c = cyc;
        expect_at(c + N + 9, 1'b0, 1'b0, 1'b1, "R4 busy segment holds path open");
        step(N + 12);
        in_sda = 1'b1; c = cyc;
        expect_at(c + 3, 1'b0, 1'b0, 1'b1, "R4 open before STOP registered");
        expect_at(c + 4, 1'b1, 1'b1, 1'b1, "R4 joined after STOP");
        step(8);

        // R6: short low on output data, no fault
        out_sda = 1'b0;
        step(T - 5);
        out_sda = 1'b1; c = cyc;
        expect_at(c + 10, 1'b1, 1'b1, 1'b1, "R6 short low raises no fault");
        step(12);

        // R6: stuck clock on input side
        in_scl = 1'b0; c = cyc;
        expect_at(c + 2 + T, 1'b1, 1'b1, 1'b1, "R6 joined just before timeout");
        expect_at(c + 3 + T, 1'b0, 1'b0, 1'b0, "R6 fault opens path");
        step(T + 6);

        // R7: forced reconnection while line still low
        en_in = 1'b0;
        step(4);
        en_in = 1'b1; c = cyc;
        expect_at(c + 2, 1'b0, 1'b0, 1'b0, "R7 still in fault");
        expect_at(c + 3, 1'b1, 1'b1, 1'b1, "R7 forced join");
        // R8: timer restarted from zero, reconnect at edge c+3
        expect_at(c + 3 + T, 1'b1, 1'b1, 1'b1, "R8 timer restarted");
        expect_at(c + 4 + T, 1'b0, 1'b0, 1'b0, "R8 refault after full window");
        step(T + 8);

        // R9: release the stuck line
        in_scl = 1'b1; c = cyc;
        expect_at(c + 2, 1'b0, 1'b0, 1'b0, "R9 fault held");
        expect_at(c + 3, 1'b0, 1'b0, 1'b1, "R9 fault cleared, open");
        expect_at(c + 3 + N, 1'b0, 1'b0, 1'b1, "R9 waiting for idle");
        expect_at(c + 4 + N, 1'b1, 1'b1, 1'b1, "R9 rejoined after idle");
        step(N + 6);

        while (sb.size() != 0) step(1);
        step(1);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung run expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule